// File: doc/BRIEF.md
# Banked Memory Mapper Register File

This block sits on the processor's write path and holds the state that decides which physical bank sits behind each window of a cartridge-style address map. Program space is divided into four 8 KB windows and pattern space into eight 1 KB windows. A select register picks one of eight bank data registers and carries two layout mode bits. A following data write loads the picked register. The block presents the physical bank of every window at once as flat vectors, and it also provides two combinational lookup ports. Each lookup port takes a processor or video address and returns the bank that serves it.

Two of the data registers each cover a 2 KB pattern pair: the even bank goes to the lower 1 KB and the odd bank to the upper 1 KB. Four more data registers each cover one 1 KB pattern window. The last two registers cover program windows. One select mode bit moves the switchable program bank between the first and third windows, and the second-to-last bank takes whichever of those two windows is left over. The other mode bit exchanges the two 4 KB halves of pattern space. A third write address sets the nametable mirroring bit. A fourth address stores a byte for external RAM control.

Top module: `bank_mapper_regs`

## Requirements
- R1: After reset, the data registers hold 0,2,4,5,6,7,0,1 for indices 0 to 7 and the select register holds 0. Pattern windows 0..7 therefore show banks 0..7, program windows 0..3 show 0, 1, PRG_BANKS-2 and PRG_BANKS-1, `mirror_o` is 1 and `ram_ctrl_o` is 0.
- R2: A write takes effect only when `wr_en` is high and `wr_addr[15]` is 1. Only address bits 14, 13 and 0 are decoded: (0,0,0) is select, (0,0,1) is data, (0,1,0) is mirroring and (0,1,1) is RAM control. Any write with bit 15 clear, or with bit 14 set, changes no output.
- R3: `wr_data[2:0]` of the last select write names the data register that a data write loads.
- R4: Registers 0 and 1 each map a 2 KB pattern pair. The lower window uses the value with bit 0 cleared and the upper window uses the value with bit 0 set. With select bit 7 clear, register 0 serves windows 0/1 and register 1 serves windows 2/3.
- R5: Registers 2, 3, 4 and 5 each map one 1 KB pattern window. With select bit 7 clear these are windows 4, 5, 6 and 7.
- R6: Select bit 7 set XORs the pattern window index with 4 (address offset with 0x1000), so the pairs serve windows 4..7 and registers 2..5 serve windows 0..3.
- R7: With select bit 6 clear, program window 0 (0x8000) takes register 6 and window 2 (0xC000) takes bank PRG_BANKS-2. With the bit set, these two are exchanged. Window 1 (0xA000) always takes register 7 and window 3 (0xE000) always takes PRG_BANKS-1.
- R8: Program bank values are cut to their low log2(PRG_BANKS) bits (at most 6) and pattern bank values to log2(CHR_BANKS) bits.
- R9: `mirror_o` equals the inverse of `wr_data[0]` from the last mirroring write.
- R10: The RAM-control write stores its full byte, which appears unchanged on `ram_ctrl_o`.
- R11: `cpu_bank_o` returns the program window selected by `cpu_addr_i[14:13]`, and `ppu_bank_o` returns the pattern window selected by `ppu_addr_i[12:10]`, with no clock delay.
- R12: Register updates happen at the rising clock edge on which the write is presented. Bank outputs follow from the registers combinationally and are valid in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Processor write strobe |
| wr_addr | input | 16 | Processor write address |
| wr_data | input | 8 | Processor write data |
| prg_bank_o | output | 4*PRG_W | Physical bank of program windows 0..3, window w at [w*PRG_W +: PRG_W] |
| chr_bank_o | output | 8*CHR_W | Physical bank of pattern windows 0..7, window i at [i*CHR_W +: CHR_W] |
| mirror_o | output | 1 | Nametable mirroring control |
| ram_ctrl_o | output | 8 | Stored RAM-control byte |
| cpu_addr_i | input | 16 | Processor lookup address |
| cpu_bank_o | output | PRG_W | Program bank serving cpu_addr_i |
| ppu_addr_i | input | 13 | Video lookup address |
| ppu_bank_o | output | CHR_W | Pattern bank serving ppu_addr_i |

## Verification
The embedded assertions watch these properties on every cycle. Writes with address bit 15 clear must leave every output unchanged. A mirroring write must invert into `mirror_o`. The select register must stay unchanged unless it is written. One of the two swappable program windows must always hold the second-to-last bank. The even/odd relation inside the active pattern pair must hold. Other behaviour is shown only by the bench's scenarios, because it depends on earlier writes: the reset contents, which register a data write reaches, the full window layout under all four mode combinations, bank truncation of out-of-range values, address aliasing through the decode mask, and the lookup ports.

// File: rtl/bmr_pkg.sv
package bmr_pkg;

   localparam int DATA_W   = 8;
   localparam int NUM_REGS = 8;

   typedef logic [NUM_REGS-1:0][DATA_W-1:0] bank_regs_t;

   typedef enum logic [2:0] {
      WK_NONE,
      WK_SELECT,
      WK_DATA,
      WK_MIRROR,
      WK_RAMCTL
   } wr_kind_e;

   function automatic bank_regs_t reset_regs();
      bank_regs_t r;
      r[0] = 8'd0; r[1] = 8'd2; r[2] = 8'd4; r[3] = 8'd5;
      r[4] = 8'd6; r[5] = 8'd7; r[6] = 8'd0; r[7] = 8'd1;
      return r;
   endfunction

endpackage

// File: rtl/bmr_write_decode.sv
module bmr_write_decode
   import bmr_pkg::*;
(
   input  logic        wr_en,
   input  logic [15:0] wr_addr,
   output wr_kind_e    kind_o
);
   always_comb begin
      kind_o = WK_NONE;
      if (wr_en && wr_addr[15] && !wr_addr[14]) begin
         unique case ({wr_addr[13], wr_addr[0]})
            2'b00:   kind_o = WK_SELECT;
            2'b01:   kind_o = WK_DATA;
            2'b10:   kind_o = WK_MIRROR;
            default: kind_o = WK_RAMCTL;
         endcase
      end
   end
endmodule

// File: rtl/bmr_reg_file.sv
module bmr_reg_file
   import bmr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  wr_kind_e          kind_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] sel_q,
   output bank_regs_t        regs_q,
   output logic              mirror_q,
   output logic [DATA_W-1:0] ramctl_q
);
   localparam int IDX_W = $clog2(NUM_REGS);

   logic [IDX_W-1:0] target;
   assign target = sel_q[IDX_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q    <= '0;
         regs_q   <= reset_regs();
         mirror_q <= 1'b0;
         ramctl_q <= '0;
      end else begin
         unique case (kind_i)
            WK_SELECT: sel_q          <= data_i;
            WK_DATA:   regs_q[target] <= data_i;
            WK_MIRROR: mirror_q       <= data_i[0];
            WK_RAMCTL: ramctl_q       <= data_i;
            default: ;
         endcase
      end
   end

   AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i != WK_SELECT) |=> $stable(sel_q)); // R3

endmodule

// File: rtl/bmr_prg_map.sv
module bmr_prg_map #(
   parameter int PRG_BANKS = 32,
   localparam int PRG_W    = $clog2(PRG_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 swap_i,
   input  logic [7:0]           bank_sw_i,
   input  logic [7:0]           bank_mid_i,
   input  logic [1:0]           win_sel_i,
   output logic [4*PRG_W-1:0]   banks_o,
   output logic [PRG_W-1:0]     bank_o
);
   localparam logic [PRG_W-1:0] LAST_BANK   = PRG_W'(PRG_BANKS - 1);
   localparam logic [PRG_W-1:0] SECOND_LAST = PRG_W'(PRG_BANKS - 2);

   logic [3:0][PRG_W-1:0] win;

   for (genvar w = 0; w < 4; w++) begin : g_win
      if (w == 1) begin : g_mid
         assign win[w] = bank_mid_i[PRG_W-1:0];
      end else if (w == 3) begin : g_last
         assign win[w] = LAST_BANK;
      end else begin : g_swap
         localparam bit SW_WHEN_SET = (w == 2);
         assign win[w] = (swap_i == SW_WHEN_SET) ? bank_sw_i[PRG_W-1:0] : SECOND_LAST;
      end
      assign banks_o[w*PRG_W +: PRG_W] = win[w];
   end

   assign bank_o = win[win_sel_i];

   AST_SECOND_LAST_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
      (banks_o[0 +: PRG_W] == SECOND_LAST) || (banks_o[2*PRG_W +: PRG_W] == SECOND_LAST)); // R7

endmodule

// File: rtl/bmr_chr_map.sv
module bmr_chr_map #(
   parameter int CHR_BANKS = 256,
   localparam int CHR_W    = $clog2(CHR_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 half_swap_i,
   input  logic [5:0][7:0]      regs_i,
   input  logic [2:0]           win_sel_i,
   output logic [8*CHR_W-1:0]   banks_o,
   output logic [CHR_W-1:0]     bank_o
);
   logic [7:0][7:0]       slot;
   logic [7:0][CHR_W-1:0] win;

   for (genvar s = 0; s < 8; s++) begin : g_slot
      if (s < 4) begin : g_pair
         assign slot[s] = {regs_i[s/2][7:1], 1'(s % 2)};
      end else begin : g_single
         assign slot[s] = regs_i[s-2];
      end
   end

   for (genvar i = 0; i < 8; i++) begin : g_win
      logic [2:0] idx;
      assign idx    = 3'(i) ^ {half_swap_i, 2'b00};
      assign win[i] = slot[idx][CHR_W-1:0];
      assign banks_o[i*CHR_W +: CHR_W] = win[i];
   end

   assign bank_o = win[win_sel_i];

   logic [2:0] pair_base;
   assign pair_base = {half_swap_i, 2'b00};

   AST_PAIR_EVEN_ODD: assert property (@(posedge clk) disable iff (!rst_n)
      (win[pair_base][0] == 1'b0) && (win[pair_base + 3'd1][0] == 1'b1)
      && (win[pair_base][CHR_W-1:1] == win[pair_base + 3'd1][CHR_W-1:1])); // R4

endmodule

// File: rtl/bank_mapper_regs.sv
module bank_mapper_regs
   import bmr_pkg::*;
#(
   parameter int PRG_BANKS = 32,
   parameter int CHR_BANKS = 256,
   localparam int PRG_W    = $clog2(PRG_BANKS),
   localparam int CHR_W    = $clog2(CHR_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [15:0]          wr_addr,
   input  logic [7:0]           wr_data,
   output logic [4*PRG_W-1:0]   prg_bank_o,
   output logic [8*CHR_W-1:0]   chr_bank_o,
   output logic                 mirror_o,
   output logic [7:0]           ram_ctrl_o,
   input  logic [15:0]          cpu_addr_i,
   output logic [PRG_W-1:0]     cpu_bank_o,
   input  logic [12:0]          ppu_addr_i,
   output logic [CHR_W-1:0]     ppu_bank_o
);
   if (PRG_BANKS < 4 || PRG_BANKS > 64 || (PRG_BANKS & (PRG_BANKS - 1)) != 0) begin : g_bad_prg
      $error("PRG_BANKS must be a power of two from 4 to 64");
   end
   if (CHR_BANKS < 8 || CHR_BANKS > 256 || (CHR_BANKS & (CHR_BANKS - 1)) != 0) begin : g_bad_chr
      $error("CHR_BANKS must be a power of two from 8 to 256");
   end

   wr_kind_e   kind;
   logic [7:0] sel_q;
   bank_regs_t regs_q;
   logic       mirror_q;

   bmr_write_decode u_dec (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .kind_o  (kind)
   );

   bmr_reg_file u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind_i   (kind),
      .data_i   (wr_data),
      .sel_q    (sel_q),
      .regs_q   (regs_q),
      .mirror_q (mirror_q),
      .ramctl_q (ram_ctrl_o)
   );

   bmr_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
      .clk        (clk),
      .rst_n      (rst_n),
      .swap_i     (sel_q[6]),
      .bank_sw_i  (regs_q[6]),
      .bank_mid_i (regs_q[7]),
      .win_sel_i  (cpu_addr_i[14:13]),
      .banks_o    (prg_bank_o),
      .bank_o     (cpu_bank_o)
   );

   bmr_chr_map #(.CHR_BANKS(CHR_BANKS)) u_chr (
      .clk         (clk),
      .rst_n       (rst_n),
      .half_swap_i (sel_q[7]),
      .regs_i      (regs_q[5:0]),
      .win_sel_i   (ppu_addr_i[12:10]),
      .banks_o     (chr_bank_o),
      .bank_o      (ppu_bank_o)
   );

   assign mirror_o = ~mirror_q;

   AST_LOW_SPACE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_addr[15]) |=> ($stable(prg_bank_o) && $stable(chr_bank_o)
                                   && $stable(mirror_o) && $stable(ram_ctrl_o))); // R2

   AST_MIRROR_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[15:13] == 3'b101 && !wr_addr[0]) |=> (mirror_o == !$past(wr_data[0]))); // R9

endmodule

// File: tb/bank_mapper_regs_tb_top.sv
`timescale 1ns/1ps
module bank_mapper_regs_tb_top;

   localparam int PRG_BANKS = 32;
   localparam int CHR_BANKS = 256;
   localparam int PW = 5;
   localparam int CW = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [15:0]       wr_addr = '0;
   logic [7:0]        wr_data = '0;
   logic [4*PW-1:0]   prg_bank_o;
   logic [8*CW-1:0]   chr_bank_o;
   logic              mirror_o;
   logic [7:0]        ram_ctrl_o;
   logic [15:0]       cpu_addr_i = 16'h8000;
   logic [PW-1:0]     cpu_bank_o;
   logic [12:0]       ppu_addr_i = '0;
   logic [CW-1:0]     ppu_bank_o;

   always #2.5 clk = ~clk;

   bank_mapper_regs #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .prg_bank_o(prg_bank_o), .chr_bank_o(chr_bank_o), .mirror_o(mirror_o),
      .ram_ctrl_o(ram_ctrl_o), .cpu_addr_i(cpu_addr_i), .cpu_bank_o(cpu_bank_o),
      .ppu_addr_i(ppu_addr_i), .ppu_bank_o(ppu_bank_o)
   );

   // item kinds: 0 program window, 1 pattern window, 2 mirror, 3 ram ctrl,
   // 4 processor lookup, 5 video lookup
   typedef struct {
      int    kind;
      int    idx;
      int    exp;
      string tag;
   } item_t;

   item_t q[$];
   item_t cur;
   int    checks = 0;
   int    errors = 0;
   bit    done = 0;

   // reference state kept from the requirements
   logic [7:0] m_regs [8];
   logic [7:0] m_sel;
   logic       m_mir;
   logic [7:0] m_ram;

   function automatic int exp_prg(int w);
      case (w)
         0:       return m_sel[6] ? PRG_BANKS - 2 : int'(m_regs[6]) % PRG_BANKS;
         1:       return int'(m_regs[7]) % PRG_BANKS;
         2:       return m_sel[6] ? int'(m_regs[6]) % PRG_BANKS : PRG_BANKS - 2;
         default: return PRG_BANKS - 1;
      endcase
   endfunction

   function automatic int exp_chr(int i);
      int j;
      int v;
      j = m_sel[7] ? (i ^ 4) : i;
      if (j < 4) v = (int'(m_regs[j/2]) & 32'hFE) | (j % 2);
      else       v = int'(m_regs[j-2]);
      return v % CHR_BANKS;
   endfunction

   function automatic int actual(item_t it);
      case (it.kind)
         0:       return int'(prg_bank_o[it.idx*PW +: PW]);
         1:       return int'(chr_bank_o[it.idx*CW +: CW]);
         2:       return int'(mirror_o);
         3:       return int'(ram_ctrl_o);
         4:       return int'(cpu_bank_o);
         default: return int'(ppu_bank_o);
      endcase
   endfunction

   // monitor: compares away from the active edge
   always @(negedge clk) begin
      #1;
      while (q.size() > 0) begin
         cur = q.pop_front();
         checks++;
         if (actual(cur) != cur.exp) begin
            errors++;
            $display("FAIL %s kind %0d idx %0d actual %0d expected %0d",
                     cur.tag, cur.kind, cur.idx, actual(cur), cur.exp);
         end
      end
   end

   task automatic push(int kind, int idx, int exp, string tag);
      item_t it;
      it.kind = kind; it.idx = idx; it.exp = exp; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic drain();
      @(negedge clk);
      #2;
   endtask

   task automatic check_all(string tag);
      for (int w = 0; w < 4; w++) push(0, w, exp_prg(w), {tag, "/R7"});
      for (int i = 0; i < 8; i++) push(1, i, exp_chr(i), {tag, "/R4_R5_R6"});
      push(2, 0, int'(m_mir), {tag, "/R9"});
      push(3, 0, int'(m_ram), {tag, "/R10"});
      drain();
   endtask

   // one write cycle; the reference state follows the decode of R2
   task automatic do_write(logic [15:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (a[15] && !a[14]) begin
         case ({a[13], a[0]})
            2'b00: m_sel = d;
            2'b01: m_regs[m_sel[2:0]] = d;
            2'b10: m_mir = ~d[0];
            default: m_ram = d;
         endcase
      end
   endtask

   task automatic check_lookups(string tag);
      for (int w = 0; w < 4; w++) begin
         cpu_addr_i = 16'h8000 | 16'(w << 13) | 16'h0123;
         push(4, w, exp_prg(w), {tag, "/R11"});
         drain();
      end
      for (int i = 0; i < 8; i++) begin
         ppu_addr_i = 13'(i << 10) | 13'h03A;
         push(5, i, exp_chr(i), {tag, "/R11"});
         drain();
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R12 actual hung expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      m_regs = '{8'd0, 8'd2, 8'd4, 8'd5, 8'd6, 8'd7, 8'd0, 8'd1};
      m_sel = 8'd0; m_mir = 1'b1; m_ram = 8'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      drain();
      check_all("R1_reset");

      // R3/R12: load each data register through the select index
      for (int r = 0; r < 8; r++) begin
         do_write(16'h8000, 8'(r));
         do_write(16'h8001, 8'(8'h11 + r * 8'h1D));
         check_all("R3_load");
      end

      // R8: values wider than the bank ranges are cut
      do_write(16'h8000, 8'h06);
      do_write(16'h8001, 8'hFB);
      do_write(16'h8000, 8'h07);
      do_write(16'h8001, 8'hE6);
      check_all("R8_trunc");

      // R6/R7: all four mode combinations
      for (int m = 0; m < 4; m++) begin
         do_write(16'h8000, 8'(m << 6) | 8'h02);
         check_all("R6_R7_modes");
         check_lookups("R11_modes");
      end

      // R2: decode mask aliases (0x9FFF acts as data, 0x8FFE as select)
      do_write(16'h8FFE, 8'h01);
      do_write(16'h9FFF, 8'h5A);
      check_all("R2_alias");

      // R9/R10: mirroring and RAM-control byte
      do_write(16'hA000, 8'h01);
      check_all("R9_mir1");
      do_write(16'hBFFE, 8'hFE);
      check_all("R9_mir0");
      do_write(16'hA001, 8'hC5);
      check_all("R10_ram");

      // R2: ignored spaces leave every output unchanged
      do_write(16'h6001, 8'h33);
      do_write(16'h0000, 8'h80);
      do_write(16'hC000, 8'h44);
      do_write(16'hE001, 8'h07);
      do_write(16'hC001, 8'hFF);
      check_all("R2_ignored");

      // R2: strobe low means no write
      @(negedge clk);
      wr_addr = 16'h8000; wr_data = 8'hC0; wr_en = 1'b0;
      @(negedge clk);
      check_all("R2_no_strobe");

      // R1: reset again restores the initial layout
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      m_regs = '{8'd0, 8'd2, 8'd4, 8'd5, 8'd6, 8'd7, 8'd0, 8'd1};
      m_sel = 8'd0; m_mir = 1'b1; m_ram = 8'd0;
      check_all("R1_rereset");
      check_lookups("R11_reset");

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule